// File: doc/BRIEF.md
# Microphone Amplifier DC Offset Trim Controller

This block measures the DC offset present at the output of a muted microphone amplifier and removes it from the converted sample stream. Gain changes applied later by an automatic level controller then cause no audible step. The host drives it through register-style inputs. These cover the amplifier enable and mute state, the ADC enable, and whether an audio clock is running (serial interface active or free-run). The host also writes a start bit that clears itself and sets a level bit that applies the offset.

The host first enables the amplifier unmuted and then mutes it. It enables the ADC and the clock source, then writes the start bit. The block drops a fixed number of settling samples and averages a power-of-two count of the samples that follow. It stores the result as the offset word and clears the start bit. The host then sets the apply bit, enables gain control and unmutes the amplifier last. If a precondition fails when the start bit is written, the run is refused. If one drops while the run is in progress, the run is abandoned. Both cases raise an error flag.

Top module: `mic_dc_trim`

## Requirements
- R1: A start is accepted only if the amplifier has been seen enabled and unmuted since it was last enabled. The record of this is lost whenever the amplifier enable goes low.
- R2: A start write is refused when the amplifier is not enabled, not muted or not yet armed (R1), or when the ADC is disabled or no clock source runs. A refused start leaves the start bit at 0 and sets the error flag.
- R3: An accepted start write sets the start bit and clears the error flag in the next cycle. The start bit returns to 0 by itself when the run completes.
- R4: The first SETTLE valid samples after an accepted start are discarded and never contribute to the offset.
- R5: The offset word becomes the floor of the mean of the next 2^LOG2N valid samples, computed as the two's complement sum shifted right arithmetically by LOG2N. It is written on the same clock edge on which the start bit clears.
- R6: While the start bit is 1, losing any of the amplifier enable, the mute, the ADC enable or the clock source abandons the run. In the next cycle the start bit is 0 and the error flag is 1, and the offset word is unchanged.
- R7: With the apply bit at 0, each valid input sample appears unchanged on the output one cycle later. The output valid always repeats the input valid one cycle later.
- R8: With the apply bit at 1, the output is the input minus the offset word, saturated to the signed sample range (largest positive 2^(SMP_W-1)-1, most negative -2^(SMP_W-1)). It has the same one-cycle latency.
- R9: After reset the offset word, the start bit, the error flag and the output valid are all 0.
- R10: Start writes while a run is in progress are ignored. The run keeps its sample count and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| amp_en_i | input | 1 | Microphone amplifier enabled |
| amp_mute_i | input | 1 | Microphone amplifier muted |
| adc_en_i | input | 1 | ADC path enabled |
| clk_run_i | input | 1 | Audio clock source running (interface active or free-run) |
| cal_start_wr_i | input | 1 | Host write of 1 to the start bit (one-cycle pulse) |
| ofs_apply_i | input | 1 | Offset apply enable |
| smp_vld_i | input | 1 | Input sample valid |
| smp_data_i | input | SMP_W | Input sample, two's complement |
| cal_busy_o | output | 1 | Start bit readback: 1 while a run is in progress |
| cal_err_o | output | 1 | Error flag for a refused or abandoned run |
| ofs_word_o | output | SMP_W | Stored offset word, two's complement |
| out_vld_o | output | 1 | Output sample valid |
| out_data_o | output | SMP_W | Output sample, two's complement |

## Verification
The averaging is tried with four sample patterns. A constant positive run detects a missing divide. A ramp of negative values detects a floor versus truncate error in the shift. A pattern with very large settling samples exposes any leak of discarded samples into the sum. A third run that includes a stray start write shows whether the sample count restarts. Each precondition is dropped on its own, both before a start and during a run, so that every term of the refusal and abandon conditions is told apart. The subtract path is swept across the whole input range with a positive and a negative offset, with the apply bit both clear and set. This separates pass-through, plain subtraction and the saturation at both ends.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/mdt_arm_guard.sv
// Tracks the enabled-unmuted-then-muted ordering and forms the start and hold conditions.
module mdt_arm_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic amp_en_i,
  input  logic amp_mute_i,
  input  logic adc_en_i,
  input  logic clk_run_i,
  output logic ready_o,
  output logic hold_o
);
  logic armed_q, armed_d;

  always_comb begin
    if (!amp_en_i) armed_d = 1'b0;
    else           armed_d = armed_q | ~amp_mute_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign hold_o  = amp_en_i & amp_mute_i & adc_en_i & clk_run_i;
  assign ready_o = armed_q & hold_o;

  // R1: arming is lost one cycle after the amplifier enable drops
  a_r1_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_en_i |=> !armed_q);
endmodule

// File: rtl/mdt_accum.sv
// Counts settling samples, then sums the measured samples and forms their mean.
module mdt_accum #(
  parameter int SMP_W  = 16,
  parameter int LOG2N  = 3,
  parameter int SETTLE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             last_o,
  output logic [SMP_W-1:0] avg_o
);
  localparam int NSMP  = 1 << LOG2N;
  localparam int TOTAL = SETTLE + NSMP;
  localparam int ACC_W = SMP_W + LOG2N;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] sum_nxt;
  logic signed [ACC_W-1:0] mean_w;
  logic                    take;
  logic                    in_meas;

  assign take    = en_i & vld_i;
  assign in_meas = (cnt_q >= SETTLE_C);
  assign sum_nxt = acc_q + ACC_W'($signed(smp_i));
  assign mean_w  = sum_nxt >>> LOG2N;
  assign avg_o   = mean_w[SMP_W-1:0];
  assign last_o  = take & (cnt_q == LAST_C);

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr_i) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (in_meas) acc_d = sum_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R4: settling samples leave the sum untouched
  a_r4_settle_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !in_meas) |=> $stable(acc_q));
  // R5: the counter never passes the last sample while a run is active
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= LAST_C));
endmodule

// File: rtl/mdt_trim_sub.sv
// Registered sample path: pass-through or saturating offset subtraction.
module mdt_trim_sub #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] ofs_i,
  output logic             vld_o,
  output logic [SMP_W-1:0] data_o
);
  localparam int DW = SMP_W + 1;
  localparam logic signed [DW-1:0] MAXV = {2'b00, {(SMP_W-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {2'b11, {(SMP_W-1){1'b0}}};

  logic signed [DW-1:0] diff;
  logic [SMP_W-1:0]     sat_w;
  logic [SMP_W-1:0]     sel_w;
  logic [SMP_W-1:0]     data_q;
  logic                 vld_q;

  assign diff = $signed({smp_i[SMP_W-1], smp_i}) - $signed({ofs_i[SMP_W-1], ofs_i});

  always_comb begin
    if (diff > MAXV)      sat_w = MAXV[SMP_W-1:0];
    else if (diff < MINV) sat_w = MINV[SMP_W-1:0];
    else                  sat_w = diff[SMP_W-1:0];
  end

  assign sel_w = apply_i ? sat_w : smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) data_q <= sel_w;
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;

  // R7: output valid repeats input valid one cycle later
  a_r7_vld_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r7_vld_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  // R7: pass-through keeps the sample value
  a_r7_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !apply_i) |=> (data_o == $past(smp_i)));
endmodule

// File: rtl/mic_dc_trim.sv
module mic_dc_trim #(
  parameter int SMP_W  = 16,
  parameter int LOG2N  = 3,
  parameter int SETTLE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             amp_en_i,
  input  logic             amp_mute_i,
  input  logic             adc_en_i,
  input  logic             clk_run_i,
  input  logic             cal_start_wr_i,
  input  logic             ofs_apply_i,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             cal_busy_o,
  output logic             cal_err_o,
  output logic [SMP_W-1:0] ofs_word_o,
  output logic             out_vld_o,
  output logic [SMP_W-1:0] out_data_o
);
  import mdt_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic ready, hold, last;
  logic [SMP_W-1:0] avg;
  cal_state_e state_q, state_d;
  logic err_q, err_d;
  logic [SMP_W-1:0] ofs_q, ofs_d;
  logic accept, refuse, abandon, finish, busy;

  mdt_arm_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .amp_en_i   (amp_en_i),
    .amp_mute_i (amp_mute_i),
    .adc_en_i   (adc_en_i),
    .clk_run_i  (clk_run_i),
    .ready_o    (ready),
    .hold_o     (hold)
  );

  assign busy    = (state_q == CAL_RUN);
  assign accept  = cal_start_wr_i & ~busy & ready;
  assign refuse  = cal_start_wr_i & ~busy & ~ready;
  assign abandon = busy & ~hold;
  assign finish  = busy & hold & last;

  mdt_accum #(
    .SMP_W  (SMP_W),
    .LOG2N  (LOG2N),
    .SETTLE (SETTLE)
  ) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (accept),
    .en_i   (busy & hold),
    .vld_i  (smp_vld_i),
    .smp_i  (smp_data_i),
    .last_o (last),
    .avg_o  (avg)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    ofs_d   = ofs_q;
    unique case (state_q)
      CAL_IDLE: begin
        if (accept) begin
          state_d = CAL_RUN;
          err_d   = 1'b0;
        end else if (refuse) begin
          err_d   = 1'b1;
        end
      end
      CAL_RUN: begin
        if (abandon) begin
          state_d = CAL_IDLE;
          err_d   = 1'b1;
        end else if (finish) begin
          state_d = CAL_IDLE;
          ofs_d   = avg;
        end
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      err_q   <= 1'b0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      ofs_q   <= ofs_d;
    end
  end

  mdt_trim_sub #(.SMP_W(SMP_W)) u_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .apply_i (ofs_apply_i),
    .vld_i   (smp_vld_i),
    .smp_i   (smp_data_i),
    .ofs_i   (ofs_q),
    .vld_o   (out_vld_o),
    .data_o  (out_data_o)
  );

  assign cal_busy_o = busy;
  assign cal_err_o  = err_q;
  assign ofs_word_o = ofs_q;

  // R3: accepted start sets busy and clears error
  a_r3_start: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cal_start_wr_i && !busy && ready) |=> (cal_busy_o && !cal_err_o));
  // R2: refused start raises the error and stays idle
  a_r2_refuse: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cal_start_wr_i && !busy && !ready) |=> (!cal_busy_o && cal_err_o));
  // R6: losing a precondition mid-run abandons it with the offset kept
  a_r6_abandon: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && !hold) |=> (!cal_busy_o && cal_err_o && $stable(ofs_word_o)));
  // R5: the offset word only changes on the completing edge
  a_r5_ofs_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy |=> $stable(ofs_word_o));
  // R10: a start write during a run does not clear or restart it
  a_r10_ignore: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && hold && !last && cal_start_wr_i) |=> cal_busy_o);
endmodule

// File: tb/mic_dc_trim_tb_top.sv
module mic_dc_trim_tb_top;
  localparam int W = 16;
  localparam int LOG2N = 3;
  localparam int N = 1 << LOG2N;
  localparam int SETTLE = 2;
  localparam int MAXV = 32767;
  localparam int MINV = -32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic amp_en = 0, amp_mute = 0, adc_en = 0, clk_run = 0;
  logic start_wr = 0, apply = 0, vld = 0;
  logic [W-1:0] din = '0;
  logic busy, err, ovld;
  logic [W-1:0] ofs, dout;

  int n_chk = 0;
  int n_fail = 0;
  int smp[SETTLE+N];

  always #2 clk = ~clk;

  mic_dc_trim #(.SMP_W(W), .LOG2N(LOG2N), .SETTLE(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .amp_en_i(amp_en), .amp_mute_i(amp_mute),
    .adc_en_i(adc_en), .clk_run_i(clk_run), .cal_start_wr_i(start_wr),
    .ofs_apply_i(apply), .smp_vld_i(vld), .smp_data_i(din),
    .cal_busy_o(busy), .cal_err_o(err), .ofs_word_o(ofs),
    .out_vld_o(ovld), .out_data_o(dout));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int sat(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic arm();
    amp_en = 1; amp_mute = 0; adc_en = 1; clk_run = 1; tick();
    amp_mute = 1; tick();
  endtask

  task automatic pulse_start();
    start_wr = 1; tick(); start_wr = 0;
  endtask

  // full calibration with smp[]; optional stray start write at sample index k
  task automatic run_cal(input string tag, input int stray_at);
    int sum = 0;
    int exp_ofs;
    for (int i = SETTLE; i < SETTLE + N; i++) sum += smp[i];
    exp_ofs = sum >>> LOG2N;
    pulse_start();
    chk(busy === 1'b1 && err === 1'b0, "R3", int'(busy), 1);
    for (int i = 0; i < SETTLE + N; i++) begin
      vld = 1; din = W'(smp[i]);
      start_wr = (i == stray_at);
      tick();
      start_wr = 0;
      if (i < SETTLE + N - 1) chk(busy === 1'b1, "R10", int'(busy), 1);
      vld = 0; tick();
    end
    chk(busy === 1'b0, "R3", int'(busy), 0);
    chk(sx(ofs) == exp_ofs, tag, sx(ofs), exp_ofs);
  endtask

  task automatic sweep(input bit ap);
    for (int x = MINV; x <= MAXV; x += 131) begin
      int e;
      vld = 1; apply = ap; din = W'(x); tick();
      e = ap ? sat(x - sx(ofs)) : x;
      chk(ovld === 1'b1 && sx(dout) == e, ap ? "R8" : "R7", sx(dout), e);
    end
    foreach (smp[k]) begin end
    vld = 1; apply = ap; din = W'(MAXV); tick();
    chk(sx(dout) == (ap ? sat(MAXV - sx(ofs)) : MAXV), "R8", sx(dout), sat(MAXV - sx(ofs)));
    din = W'(MINV); tick();
    chk(sx(dout) == (ap ? sat(MINV - sx(ofs)) : MINV), "R8", sx(dout), sat(MINV - sx(ofs)));
    vld = 0; tick();
    chk(ovld === 1'b0, "R7", int'(ovld), 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick(); tick(); tick();
    // R9 reset state
    chk(busy === 1'b0, "R9", int'(busy), 0);
    chk(err === 1'b0, "R9", int'(err), 0);
    chk(ofs === '0, "R9", sx(ofs), 0);
    chk(ovld === 1'b0, "R9", int'(ovld), 0);

    // R1: enabled but never unmuted -> refused
    amp_en = 1; amp_mute = 1; adc_en = 1; clk_run = 1; tick();
    pulse_start(); tick();
    chk(busy === 1'b0 && err === 1'b1, "R1", int'(busy), 0);
    // R1: arming lost when amp disabled
    arm(); amp_en = 0; tick(); amp_en = 1; tick();
    pulse_start(); tick();
    chk(busy === 1'b0 && err === 1'b1, "R1", int'(busy), 0);

    // R2: each precondition alone
    for (int c = 0; c < 3; c++) begin
      arm();
      if (c == 0) amp_mute = 0;
      if (c == 1) adc_en = 0;
      if (c == 2) clk_run = 0;
      pulse_start(); tick();
      chk(busy === 1'b0 && err === 1'b1, "R2", int'(busy), 0);
    end

    // R5/R4 pattern A: constant positive, settle junk huge
    arm();
    foreach (smp[i]) smp[i] = (i < SETTLE) ? 30000 : 100;
    run_cal("R5", -1);
    chk(sx(ofs) == 100, "R4", sx(ofs), 100);
    // pattern B: negative ramp (floor check)
    foreach (smp[i]) smp[i] = (i < SETTLE) ? -32768 : -(3 * i + 1);
    run_cal("R5", -1);
    // pattern C: mixed with stray start (R10)
    foreach (smp[i]) smp[i] = (i % 2 == 0) ? 523 : -77;
    run_cal("R10", SETTLE + 2);

    // R8/R7 sweeps with negative offset from pattern C? use positive one
    foreach (smp[i]) smp[i] = 1200 + 17 * i;
    run_cal("R5", -1);
    sweep(1'b0);
    sweep(1'b1);
    foreach (smp[i]) smp[i] = -2500 - 3 * i;
    run_cal("R5", -1);
    sweep(1'b1);

    // R6 abandon for each precondition
    for (int c = 0; c < 4; c++) begin
      int keep;
      arm();
      keep = sx(ofs);
      pulse_start();
      for (int i = 0; i < SETTLE + 2; i++) begin
        vld = 1; din = W'(9000); tick();
      end
      vld = 0;
      if (c == 0) amp_mute = 0;
      if (c == 1) amp_en = 0;
      if (c == 2) adc_en = 0;
      if (c == 3) clk_run = 0;
      tick();
      chk(busy === 1'b0 && err === 1'b1, "R6", int'(busy), 0);
      chk(sx(ofs) == keep, "R6", sx(ofs), keep);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule